// File: doc/BRIEF.md
# Floating-Point to Integer Converter

This block turns an IEEE-754 binary32 or binary64 operand into a 32-bit or 64-bit integer. The integer can be signed or unsigned. Software picks the rounding through a 2-bit mode, or forces truncation with a separate select. Two rules differ from common practice:

- An unsigned conversion rejects every negative nonzero input before any rounding takes place. It returns 0 and flags the input as invalid.
- A signed conversion of any NaN returns all ones (-1) and does not saturate.

The converter is a two-stage pipeline.

**Stage one** classifies the operand and registers the result together with the aligned integer part and the round and sticky bits. The class is one of four values: `CLS_ZERO`, `CLS_FINITE`, `CLS_INF` and `CLS_NAN`. Stage one also folds the truncate select into an effective rounding mode. The four modes are `RM_NEAR`, `RM_TRUNC`, `RM_FLOOR` and `RM_CEIL`.

**Stage two** rounds the magnitude and then applies the range and special-case rules, selected by the registered class:

- `CLS_ZERO` always goes to a zero result with no flags.
- `CLS_NAN` goes to -1 for a signed destination and to the unsigned maximum for an unsigned one.
- `CLS_INF` saturates.
- `CLS_FINITE` either produces the rounded value or saturates when it is out of range.

A request accepted with `in_valid` appears on the outputs two clock edges later with `out_valid`. The outputs hold their last value while no result is arriving.

Top module: `fp2int_conv`

## Requirements
- R1: With `dst_signed`=0, any negative input that is neither zero nor NaN returns 0 with `invalid`=1 and `inexact`=0. This covers -inf, negative subnormals and values that would round to zero.
- R2: With `dst_signed`=1, any NaN (any sign, quiet or signalling) returns all 64 result bits set, with `invalid`=1.
- R3: With `trunc_en`=1, the result is rounded toward zero whatever `round_mode` holds.
- R4: With `trunc_en`=0, `round_mode` selects the rounding: 0 is nearest with ties to even, 1 is toward zero, 2 is toward minus infinity and 3 is toward plus infinity.
- R5: With `src_dbl`=1, all 64 bits of `operand` are a binary64 value (sign bit 63, exponent bits 62:52, fraction bits 51:0). With `src_dbl`=0, `operand[31:0]` is a binary32 value (sign bit 31, exponent bits 30:23, fraction bits 22:0) and `operand[63:32]` has no effect. `dst_wide`=1 gives a 64-bit integer.
- R6: With `dst_wide`=0 the integer is 32 bits wide. `result[63:32]` is the sign extension of bit 31 for signed destinations and zero for unsigned ones.
- R7: A finite or infinite input whose rounded value lies outside the destination range returns that range's maximum or minimum with `invalid`=1. A NaN with an unsigned destination returns the unsigned maximum with `invalid`=1.
- R8: `inexact`=1 exactly when a conversion with `invalid`=0 discards nonzero fraction bits. `invalid` and `inexact` are never both set.
- R9: +0 and -0 return 0 with both flags clear, for every destination.
- R10: `out_valid` follows `in_valid` by exactly two clock cycles. The result and flags keep their values in any cycle that brings no new result. After reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand and controls are valid this cycle |
| operand | input | 64 | Floating-point operand (binary32 in bits 31:0 when `src_dbl`=0) |
| src_dbl | input | 1 | 1: binary64 source, 0: binary32 source |
| dst_signed | input | 1 | 1: signed destination, 0: unsigned |
| dst_wide | input | 1 | 1: 64-bit destination, 0: 32-bit |
| trunc_en | input | 1 | Force rounding toward zero |
| round_mode | input | 2 | Rounding mode when `trunc_en`=0 |
| out_valid | output | 1 | Result and flags are new this cycle |
| result | output | 64 | Integer result |
| invalid | output | 1 | Invalid-operation flag |
| inexact | output | 1 | Inexact flag |

## Verification
The clocked assertions take for granted that `in_valid` and the controls are never X once reset has ended. The stage-one register is loaded only on `in_valid`, so an unknown control would propagate into the classification that the properties inspect. The stimulus holds every control at a defined value from reset onward.

The stimulus changes inputs only on the falling edge. It sweeps every combination of signedness, width, truncation and rounding mode across:

- binary32 and binary64 exponents spanning the fractional, exact and overflow regions of both destination widths;
- exact powers of two, exact ties and non-tie fractions;
- a fixed set of zeros, subnormals, infinities, NaNs and near-boundary values.

The binary32 operands always carry a nonzero pattern in the upper word.

// File: rtl/fcvt_pkg.sv
package fcvt_pkg;
    // Source formats
    localparam int DP_EXP_W   = 11;
    localparam int DP_FRAC_W  = 52;
    localparam int DP_BIAS    = (1 << (DP_EXP_W - 1)) - 1;
    localparam int SP_EXP_W   = 8;
    localparam int SP_FRAC_W  = 23;
    localparam int SP_BIAS    = (1 << (SP_EXP_W - 1)) - 1;
    localparam int SP_W       = 1 + SP_EXP_W + SP_FRAC_W;
    // Destination
    localparam int INT_W      = 64;
    localparam int HALF_W     = INT_W / 2;
    // Datapath geometry
    localparam int SIG_W      = DP_FRAC_W + 1;
    localparam int EXP_W      = DP_EXP_W + 2;
    localparam int FX_W       = INT_W + 2;            // fraction bits kept after alignment
    localparam int ALIGN_BIAS = FX_W - DP_FRAC_W;     // shift for exponent 0
    localparam int MAX_SHIFT  = INT_W + ALIGN_BIAS;
    localparam int SH_W       = $clog2(MAX_SHIFT + 1);
    localparam int ALN_W      = SIG_W + MAX_SHIFT;
    localparam int IP_W       = ALN_W - FX_W;         // integer part width
    localparam int MAG_W      = IP_W + 1;             // after rounding increment

    typedef enum logic [1:0] {
        CLS_ZERO   = 2'd0,
        CLS_FINITE = 2'd1,
        CLS_INF    = 2'd2,
        CLS_NAN    = 2'd3
    } fcls_e;

    typedef enum logic [1:0] {
        RM_NEAR  = 2'd0,
        RM_TRUNC = 2'd1,
        RM_FLOOR = 2'd2,
        RM_CEIL  = 2'd3
    } rmode_e;

    typedef struct packed {
        logic            neg;
        fcls_e           cls;
        logic [IP_W-1:0] ip;
        logic            rbit;
        logic            sbit;
        logic            huge;
        logic            sgn;
        logic            wide;
        rmode_e          rm;
    } stage_t;
endpackage

// File: rtl/fcvt_unpack.sv
module fcvt_unpack
    import fcvt_pkg::*;
(
    input  logic [INT_W-1:0]        raw,
    input  logic                    dbl,
    output logic                    neg,
    output fcls_e                   cls,
    output logic signed [EXP_W-1:0] exp_u,
    output logic [SIG_W-1:0]        sig
);
    logic [DP_EXP_W-1:0]  ef;
    logic [DP_FRAC_W-1:0] fr;
    logic                 e_all1;
    logic                 e_zero;
    logic [EXP_W-1:0]     bias;

    always_comb begin
        if (dbl) begin
            neg    = raw[INT_W-1];
            ef     = raw[DP_FRAC_W +: DP_EXP_W];
            fr     = raw[DP_FRAC_W-1:0];
            e_all1 = &raw[DP_FRAC_W +: DP_EXP_W];
            bias   = EXP_W'(DP_BIAS);
        end else begin
            neg    = raw[SP_W-1];
            ef     = DP_EXP_W'(raw[SP_FRAC_W +: SP_EXP_W]);
            fr     = {raw[SP_FRAC_W-1:0], {(DP_FRAC_W - SP_FRAC_W){1'b0}}};
            e_all1 = &raw[SP_FRAC_W +: SP_EXP_W];
            bias   = EXP_W'(SP_BIAS);
        end
        e_zero = (ef == '0);
        sig    = {!e_zero, fr};
        exp_u  = (e_zero ? EXP_W'(1) : EXP_W'(ef)) - bias;
        if (e_all1)
            cls = (fr == '0) ? CLS_INF : CLS_NAN;
        else if (e_zero && fr == '0)
            cls = CLS_ZERO;
        else
            cls = CLS_FINITE;
    end
endmodule

// File: rtl/fcvt_align.sv
module fcvt_align
    import fcvt_pkg::*;
(
    input  logic signed [EXP_W-1:0] exp_u,
    input  logic [SIG_W-1:0]        sig,
    output logic [IP_W-1:0]         ip,
    output logic                    rbit,
    output logic                    sbit,
    output logic                    huge
);
    localparam logic signed [EXP_W-1:0] HI_E = EXP_W'(INT_W);
    localparam logic signed [EXP_W-1:0] LO_E = EXP_W'(-ALIGN_BIAS);

    logic [ALN_W-1:0] aligned;
    logic [SH_W-1:0]  sh;
    logic             tiny;

    always_comb begin
        huge    = (exp_u > HI_E);
        tiny    = (exp_u < LO_E);
        sh      = SH_W'(exp_u - LO_E);
        aligned = ALN_W'(sig) << sh;
        ip      = aligned[ALN_W-1:FX_W];
        rbit    = aligned[FX_W-1];
        sbit    = |aligned[FX_W-2:0];
        if (tiny) begin
            ip   = '0;
            rbit = 1'b0;
            sbit = |sig;
        end else if (huge) begin
            ip   = '0;
            rbit = 1'b0;
            sbit = 1'b0;
        end
    end
endmodule

// File: rtl/fcvt_limit.sv
module fcvt_limit
    import fcvt_pkg::*;
(
    input  logic             neg,
    input  fcls_e            cls,
    input  logic [MAG_W-1:0] mag,
    input  logic             huge,
    input  logic             lost,
    input  logic             sgn,
    input  logic             wide,
    output logic [INT_W-1:0] res,
    output logic             inv,
    output logic             inx
);
    logic [MAG_W-1:0] umax, smax, nlim, plim;

    always_comb begin
        umax = wide ? MAG_W'({INT_W{1'b1}}) : MAG_W'({HALF_W{1'b1}});
        smax = umax >> 1;
        nlim = smax + MAG_W'(1);
        plim = sgn ? smax : umax;
        res  = '0;
        inv  = 1'b0;
        inx  = 1'b0;
        unique case (cls)
            CLS_ZERO: res = '0;
            CLS_NAN: begin
                inv = 1'b1;
                res = sgn ? {INT_W{1'b1}} : umax[INT_W-1:0];
            end
            CLS_INF: begin
                inv = 1'b1;
                if (neg) res = sgn ? -nlim[INT_W-1:0] : '0;
                else     res = plim[INT_W-1:0];
            end
            CLS_FINITE: begin
                if (neg && !sgn) begin
                    inv = 1'b1;
                    res = '0;
                end else if (neg) begin
                    if (huge || mag > nlim) begin
                        inv = 1'b1;
                        res = -nlim[INT_W-1:0];
                    end else begin
                        res = -mag[INT_W-1:0];
                        inx = lost;
                    end
                end else if (huge || mag > plim) begin
                    inv = 1'b1;
                    res = plim[INT_W-1:0];
                end else begin
                    res = mag[INT_W-1:0];
                    inx = lost;
                end
            end
        endcase
    end
endmodule

// File: rtl/fp2int_conv.sv
module fp2int_conv
    import fcvt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [INT_W-1:0] operand,
    input  logic             src_dbl,
    input  logic             dst_signed,
    input  logic             dst_wide,
    input  logic             trunc_en,
    input  logic [1:0]       round_mode,
    output logic             out_valid,
    output logic [INT_W-1:0] result,
    output logic             invalid,
    output logic             inexact
);
    // Stage one: classify and align
    logic                    u_neg;
    fcls_e                   u_cls;
    logic signed [EXP_W-1:0] u_exp;
    logic [SIG_W-1:0]        u_sig;
    stage_t                  s1_d, s1_q;
    logic                    v1_q;

    fcvt_unpack u_unpack (
        .raw(operand), .dbl(src_dbl), .neg(u_neg), .cls(u_cls),
        .exp_u(u_exp), .sig(u_sig)
    );

    fcvt_align u_align (
        .exp_u(u_exp), .sig(u_sig), .ip(s1_d.ip), .rbit(s1_d.rbit),
        .sbit(s1_d.sbit), .huge(s1_d.huge)
    );

    always_comb begin
        s1_d.neg  = u_neg;
        s1_d.cls  = u_cls;
        s1_d.sgn  = dst_signed;
        s1_d.wide = dst_wide;
        s1_d.rm   = trunc_en ? RM_TRUNC : rmode_e'(round_mode);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            v1_q <= 1'b0;
            s1_q <= '0;
        end else begin
            v1_q <= in_valid;
            if (in_valid) s1_q <= s1_d;
        end
    end

    // Stage two: round and limit
    logic             inc, lost;
    logic [MAG_W-1:0] mag;
    logic [INT_W-1:0] l_res;
    logic             l_inv, l_inx;

    always_comb begin
        lost = s1_q.rbit | s1_q.sbit;
        unique case (s1_q.rm)
            RM_NEAR:  inc = s1_q.rbit & (s1_q.sbit | s1_q.ip[0]);
            RM_TRUNC: inc = 1'b0;
            RM_FLOOR: inc = s1_q.neg & lost;
            RM_CEIL:  inc = !s1_q.neg & lost;
        endcase
        mag = MAG_W'(s1_q.ip) + MAG_W'(inc);
    end

    fcvt_limit u_limit (
        .neg(s1_q.neg), .cls(s1_q.cls), .mag(mag), .huge(s1_q.huge),
        .lost(lost), .sgn(s1_q.sgn), .wide(s1_q.wide),
        .res(l_res), .inv(l_inv), .inx(l_inx)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            result    <= '0;
            invalid   <= 1'b0;
            inexact   <= 1'b0;
        end else begin
            out_valid <= v1_q;
            if (v1_q) begin
                result  <= l_res;
                invalid <= l_inv;
                inexact <= l_inx;
            end
        end
    end

    // R10
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        v1_q |=> out_valid);
    // R10
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !v1_q |=> ($stable(result) && $stable(invalid) && $stable(inexact)));
    // R1
    uns_negative_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (v1_q && !s1_q.sgn && s1_q.neg && s1_q.cls != CLS_NAN && s1_q.cls != CLS_ZERO)
        |=> (result == '0 && invalid && !inexact));
    // R2
    signed_nan_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (v1_q && s1_q.sgn && s1_q.cls == CLS_NAN) |=> (result == '1 && invalid));
    // R6
    narrow_unsigned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (v1_q && !s1_q.wide && !s1_q.sgn) |=> (result[INT_W-1:HALF_W] == '0));
    // R8
    flag_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !(invalid && inexact));
    // R9
    zero_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (v1_q && s1_q.cls == CLS_ZERO) |=> (result == '0 && !invalid && !inexact));
endmodule

// File: tb/fp2int_conv_test.sv
`timescale 1ns/1ps
module fp2int_conv_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [63:0] operand = '0;
    logic        src_dbl = 1'b0, dst_signed = 1'b0, dst_wide = 1'b0, trunc_en = 1'b0;
    logic [1:0]  round_mode = 2'd0;
    logic        out_valid, invalid, inexact;
    logic [63:0] result;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    fp2int_conv uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .operand(operand),
        .src_dbl(src_dbl), .dst_signed(dst_signed), .dst_wide(dst_wide),
        .trunc_en(trunc_en), .round_mode(round_mode), .out_valid(out_valid),
        .result(result), .invalid(invalid), .inexact(inexact)
    );

    // Arithmetic reference derived from the requirements
    function automatic void model(input logic [63:0] op, input bit dbl, sgn, wide, chp,
                                  input bit [1:0] rm, output logic [63:0] r,
                                  output bit inv, output bit inx, output string tag);
        int E, bias, fw, emax, e2, sh, cmpc, rme;
        logic [127:0] F, m, ip, rem, half, mag, umax, smax, lim;
        bit S, big, inc;
        if (dbl) begin
            E = int'(op[62:52]); F = 128'(op[51:0]); S = op[63];
            bias = 1023; fw = 52; emax = 2047;
        end else begin
            E = int'(op[30:23]); F = 128'(op[22:0]); S = op[31];
            bias = 127; fw = 23; emax = 255;
        end
        umax = (128'd1 << (wide ? 64 : 32)) - 128'd1;
        smax = umax >> 1;
        r = '0; inv = 0; inx = 0;
        tag = wide ? "R5" : "R6";
        if (E == emax && F != 0) begin
            inv = 1; r = sgn ? '1 : umax[63:0]; tag = sgn ? "R2" : "R7"; return;
        end
        if (E == 0 && F == 0) begin tag = "R9"; return; end
        if (S && !sgn) begin inv = 1; tag = "R1"; return; end
        if (E == emax) begin
            inv = 1; tag = "R7";
            r = sgn ? (S ? -(smax[63:0] + 64'd1) : smax[63:0]) : umax[63:0];
            return;
        end
        m = (E == 0) ? F : (F | (128'd1 << fw));
        e2 = ((E == 0) ? 1 : E) - bias - fw;
        big = 0; cmpc = 0; ip = '0;
        if (e2 >= 0) begin
            if (e2 > 70) big = 1; else ip = m << e2;
        end else begin
            sh = -e2;
            if (sh > 120) cmpc = 1;
            else begin
                ip = m >> sh;
                rem = m - (ip << sh);
                half = 128'd1 << (sh - 1);
                if (rem == 0) cmpc = 0;
                else if (rem < half) cmpc = 1;
                else if (rem == half) cmpc = 2;
                else cmpc = 3;
            end
        end
        rme = chp ? 1 : int'(rm);
        case (rme)
            0: inc = (cmpc == 3) || (cmpc == 2 && ip[0]);
            1: inc = 0;
            2: inc = S && cmpc != 0;
            default: inc = !S && cmpc != 0;
        endcase
        mag = ip + 128'(inc);
        if (sgn && S) begin
            if (big || mag > smax + 128'd1) begin
                inv = 1; r = -(smax[63:0] + 64'd1); tag = "R7";
            end else r = -mag[63:0];
        end else begin
            lim = sgn ? smax : umax;
            if (big || mag > lim) begin inv = 1; r = lim[63:0]; tag = "R7"; end
            else r = mag[63:0];
        end
        if (!inv && cmpc != 0) begin
            inx = 1; tag = chp ? "R3,R8" : "R4,R8";
        end
    endfunction

    // Drive one request at a falling edge, sample two cycles later
    task automatic run_vec(input logic [63:0] op, input bit dbl, input int cfg);
        logic [63:0] er; bit ei, ex; string tg;
        operand = op; src_dbl = dbl;
        dst_signed = cfg[0]; dst_wide = cfg[1]; trunc_en = cfg[2]; round_mode = cfg[4:3];
        in_valid = 1'b1;
        model(op, dbl, cfg[0], cfg[1], cfg[2], cfg[4:3], er, ei, ex, tg);
        @(negedge clk);
        @(negedge clk);
        checks++;
        if (!out_valid || result !== er || invalid !== ei || inexact !== ex) begin
            errors++;
            $display("FAIL %s op=%h dbl=%0d cfg=%0d: got v=%0d r=%h inv=%0d inx=%0d exp v=1 r=%h inv=%0d inx=%0d",
                     tg, op, dbl, cfg, out_valid, result, invalid, inexact, er, ei, ex);
        end
    endtask

    task automatic check_idle(input string tg, input logic [63:0] er);
        checks++;
        if (out_valid !== 1'b0 || result !== er) begin
            errors++;
            $display("FAIL %s idle: got v=%0d r=%h exp v=0 r=%h", tg, out_valid, result, er);
        end
    endtask

    logic [31:0] sp_special [13] = '{32'h00000000, 32'h80000000, 32'h7F800000, 32'hFF800000,
        32'h7FC00000, 32'h7F800001, 32'hFFC00000, 32'h00000001, 32'h80000001,
        32'h3F000000, 32'hBF000000, 32'h7F7FFFFF, 32'hBEFFFFFF};
    logic [63:0] dp_special [14] = '{64'h0, 64'h8000000000000000, 64'h7FF0000000000000,
        64'hFFF0000000000000, 64'h7FF8000000000000, 64'hFFF0000000000001,
        64'h0000000000000001, 64'h8000000000000001, 64'h3FE0000000000000,
        64'hBFE8000000000000, 64'h3FDFFFFFFFFFFFFF, 64'h7FEFFFFFFFFFFFFF,
        64'h41EFFFFFFFF00000, 64'hC1E0000000100000};

    initial begin
        logic [63:0] last;
        repeat (3) @(negedge clk);
        // R10: reset state
        check_idle("R10", 64'h0);
        checks++;
        if (invalid !== 1'b0 || inexact !== 1'b0) begin
            errors++;
            $display("FAIL R10 reset flags: got inv=%0d inx=%0d exp 0 0", invalid, inexact);
        end
        rst_n = 1'b1;
        @(negedge clk);
        check_idle("R10", 64'h0);

        for (int i = 0; i < 13; i++)
            for (int c = 0; c < 32; c++)
                run_vec({32'hDEADBEEF, sp_special[i]}, 1'b0, c);
        for (int i = 0; i < 14; i++)
            for (int c = 0; c < 32; c++)
                run_vec(dp_special[i], 1'b1, c);
        for (int e = 120; e <= 192; e++)
            for (int k = 0; k < 3; k++)
                for (int s = 0; s < 2; s++) begin
                    logic [22:0] fr;
                    fr = (k == 0) ? 23'h0 : (k == 1) ? 23'h400000 : 23'h0AAAAB;
                    for (int c = 0; c < 32; c++)
                        run_vec({32'hA5C3_0F96, s[0], e[7:0], fr}, 1'b0, c);
                end
        for (int e = 1010; e <= 1090; e++)
            for (int k = 0; k < 3; k++)
                for (int s = 0; s < 2; s++) begin
                    logic [51:0] fr;
                    fr = (k == 0) ? 52'h0 : (k == 1) ? 52'h8000000000000 : 52'h5555555555555;
                    for (int c = 0; c < 32; c++)
                        run_vec({s[0], e[10:0], fr}, 1'b1, c);
                end

        // R10: valid drops two cycles after in_valid, outputs held
        last = result;
        in_valid = 1'b0;
        operand = 64'h3FF0000000000000;
        @(negedge clk);
        checks++;
        if (out_valid !== 1'b1) begin
            errors++;
            $display("FAIL R10 pipeline tail: got v=%0d exp v=1", out_valid);
        end
        @(negedge clk);
        check_idle("R10", last);
        repeat (3) @(negedge clk);
        check_idle("R10", last);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule